// File: doc/BRIEF.md
# Reversible-Gate Carry Save Adder

This block reduces three equal-width operands to two vectors, a partial sum and a carry, without any carry moving between bit positions. Every bit position is handled by one four-input, four-output reversible gate. Its outputs are one pass-through line, one two-input XOR line, the three-input XOR, and a fourth line that gives the majority of the three operand bits when its fourth input is held at zero. The three-input XOR becomes the partial-sum bit and the majority line becomes the carry bit. The two lines that carry no result are brought out on a garbage bus, so the full gate output stays observable.

A downstream carry-propagate stage forms the final result as `psum_o + (carry_o << 1)`. Because no bit depends on its neighbours, the block's delay is the delay of one gate whatever the width. An optional built-in check, enabled by a parameter, asserts that the reduced pair always adds back to the sum of the three operands.

Top module: `rev_csa`

## Requirements
- R1: For every bit i, `psum_o[i]` equals `x_i[i] ^ y_i[i] ^ z_i[i]`.
- R2: For every bit i, `carry_o[i]` is 1 exactly when at least two of `x_i[i]`, `y_i[i]`, `z_i[i]` are 1.
- R3: For all inputs, `psum_o + 2*carry_o` equals `x_i + y_i + z_i`, evaluated in WIDTH+2 bits.
- R4: Garbage bit `garbage_o[2*i]` equals `x_i[i]`, the gate's pass-through line.
- R5: Garbage bit `garbage_o[2*i+1]` equals `x_i[i] ^ y_i[i]`.
- R6: Bit positions are independent. Changing any operand bit at position k leaves `psum_o`, `carry_o` and the garbage pair at every other position unchanged.
- R7: With all operands zero, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| x_i | input | WIDTH | First operand (gate input A per bit) |
| y_i | input | WIDTH | Second operand (gate input B per bit) |
| z_i | input | WIDTH | Third operand (gate input C per bit) |
| psum_o | output | WIDTH | Partial-sum vector, bit i has weight 2^i |
| carry_o | output | WIDTH | Carry vector, bit i has weight 2^(i+1) |
| garbage_o | output | 2*WIDTH | Unused gate lines, pair {A^B, A} per bit |

## Verification
The bench builds the block at its default WIDTH of 4 with the built-in sum check enabled. At that width all 4096 operand triples can be swept, so every per-bit truth-table row, every weighted-sum identity and the all-ones overflow corner are checked against arithmetic computed in the bench. For independence, single operand bits are flipped at each position over several base patterns, and the untouched positions are compared before and after each flip.

// File: rtl/rev_csa_pkg.sv
package rev_csa_pkg;
  localparam int unsigned GARB_PER_BIT = 2;

  typedef struct packed {
    logic p;
    logic q;
    logic r;
    logic s;
  } mtsg_out_t;
endpackage

// File: rtl/mtsg_gate.sv
module mtsg_gate
  import rev_csa_pkg::*;
(
  input  logic      a_i,
  input  logic      b_i,
  input  logic      c_i,
  input  logic      d_i,
  output mtsg_out_t o_o
);
  logic ab_x;

  assign ab_x   = a_i ^ b_i;
  assign o_o.p  = a_i;
  assign o_o.q  = ab_x;
  assign o_o.r  = ab_x ^ c_i;
  assign o_o.s  = (ab_x & c_i) ^ (a_i & b_i) ^ d_i;

  always_comb begin
    // R1
    gate_sum_chk: assert (o_o.r == (o_o.q ^ c_i))
      else $error("gate sum line inconsistent");
    // R4
    gate_pass_chk: assert (o_o.p == a_i)
      else $error("gate pass line mismatch");
  end
endmodule

// File: rtl/csa_bit_cell.sv
module csa_bit_cell
  import rev_csa_pkg::*;
(
  input  logic       x_i,
  input  logic       y_i,
  input  logic       z_i,
  output logic       sum_o,
  output logic       cry_o,
  output logic [1:0] garb_o
);
  mtsg_out_t g;

  mtsg_gate gate_i (
    .a_i (x_i),
    .b_i (y_i),
    .c_i (z_i),
    .d_i (1'b0),
    .o_o (g)
  );

  assign sum_o  = g.r;
  assign cry_o  = g.s;
  assign garb_o = {g.q, g.p};

  always_comb begin
    // R2
    cell_maj_chk: assert (cry_o == ((x_i & y_i) | (z_i & (x_i | y_i))))
      else $error("cell carry is not majority");
    // R5
    cell_garb_chk: assert (garb_o[1] == (x_i != y_i))
      else $error("cell garbage xor mismatch");
  end
endmodule

// File: rtl/rev_csa.sv
module rev_csa
  import rev_csa_pkg::*;
#(
  parameter int unsigned WIDTH    = 4,
  parameter bit          CHECK_EN = 1'b1
) (
  input  logic [WIDTH-1:0]              x_i,
  input  logic [WIDTH-1:0]              y_i,
  input  logic [WIDTH-1:0]              z_i,
  output logic [WIDTH-1:0]              psum_o,
  output logic [WIDTH-1:0]              carry_o,
  output logic [GARB_PER_BIT*WIDTH-1:0] garbage_o
);
  localparam int unsigned SW = WIDTH + 2;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    csa_bit_cell cell_i (
      .x_i    (x_i[i]),
      .y_i    (y_i[i]),
      .z_i    (z_i[i]),
      .sum_o  (psum_o[i]),
      .cry_o  (carry_o[i]),
      .garb_o (garbage_o[GARB_PER_BIT*i +: GARB_PER_BIT])
    );
  end

  if (CHECK_EN) begin : g_sum_chk
    logic [SW-1:0] lhs, rhs;
    always_comb begin
      lhs = SW'(psum_o) + (SW'(carry_o) << 1);
      rhs = SW'(x_i) + SW'(y_i) + SW'(z_i);
      // R3
      weighted_sum_chk: assert (lhs == rhs)
        else $error("reduced pair does not add back to operand sum");
    end
  end
endmodule

// File: tb/rev_csa_tb_top.sv
module rev_csa_tb_top;
  localparam int W          = 4;
  localparam int CLK_PERIOD = 10;
  localparam int N          = 1 << W;

  logic         clk;
  logic [W-1:0] x, y, z, ps, cy;
  logic [2*W-1:0] gb;
  int checks = 0;
  int errors = 0;

  rev_csa #(.WIDTH(W), .CHECK_EN(1'b1)) dut_i (
    .x_i(x), .y_i(y), .z_i(z),
    .psum_o(ps), .carry_o(cy), .garbage_o(gb)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s act=%0d exp=%0d (x=%0d y=%0d z=%0d)", req, act, exp, x, y, z);
    end
  endtask

  task automatic apply(input int a, input int b, input int c);
    @(posedge clk);
    x = W'(a); y = W'(b); z = W'(c);
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    x = '0; y = '0; z = '0;
    // R7: all-zero operands
    apply(0, 0, 0);
    chk("R7 psum", int'(ps), 0);
    chk("R7 carry", int'(cy), 0);
    chk("R7 garbage", int'(gb), 0);

    // exhaustive sweep
    for (int a = 0; a < N; a++)
      for (int b = 0; b < N; b++)
        for (int c = 0; c < N; c++) begin
          int ep, ec, eg;
          apply(a, b, c);
          ep = 0; ec = 0; eg = 0;
          for (int i = 0; i < W; i++) begin
            int ab, bb, cb;
            ab = (a >> i) & 1; bb = (b >> i) & 1; cb = (c >> i) & 1;
            ep |= ((ab + bb + cb) & 1) << i;
            ec |= (((ab + bb + cb) >= 2) ? 1 : 0) << i;
            eg |= (ab << (2*i)) | ((ab ^ bb) << (2*i+1));
          end
          chk("R1 psum", int'(ps), ep);
          chk("R2 carry", int'(cy), ec);
          chk("R3 weighted sum", int'(ps) + 2*int'(cy), a + b + c);
          chk("R4 garbage pass", int'(gb) & 'h55, eg & 'h55);
          chk("R5 garbage xor", int'(gb) & 'hAA, eg & 'hAA);
        end

    // R3 overflow corner: all ones
    apply(N-1, N-1, N-1);
    chk("R3 all ones psum", int'(ps), N-1);
    chk("R3 all ones carry", int'(cy), N-1);

    // R6: flip one bit at position k, other positions must not move
    for (int base = 0; base < N; base += 5) begin
      for (int k = 0; k < W; k++) begin
        for (int op = 0; op < 3; op++) begin
          int p0, c0, g0, ma, mb, mc, m, gm;
          apply(base, (base * 7) % N, (base * 3 + 1) % N);
          p0 = int'(ps); c0 = int'(cy); g0 = int'(gb);
          ma = (op == 0) ? (1 << k) : 0;
          mb = (op == 1) ? (1 << k) : 0;
          mc = (op == 2) ? (1 << k) : 0;
          apply(base ^ ma, ((base * 7) % N) ^ mb, ((base * 3 + 1) % N) ^ mc);
          m  = (N - 1) & ~(1 << k);
          gm = ((1 << (2*W)) - 1) & ~(3 << (2*k));
          chk("R6 psum other bits", int'(ps) & m, p0 & m);
          chk("R6 carry other bits", int'(cy) & m, c0 & m);
          chk("R6 garbage other bits", int'(gb) & gm, g0 & gm);
        end
      end
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule